// File: doc/BRIEF.md
# Interrupt Coalescing Status Unit

This block merges two streams of completion events into one interrupt line. One stream reports receive descriptors written back and the other reports transmit descriptors returned. Each stream has its own coalescer, and each coalescer raises one of two sources. The count source is raised when enough events have gathered. The timeout source is raised when the oldest pending event has waited too long. Thirty-two interrupt sources share one raw status register, one enable register and one masked view. Twenty-eight of those sources take one-cycle event pulses directly from the surrounding logic. Each of the four coalescer outputs occupies a fixed bit that software decodes.

Software uses a small word-addressed register port. Through it, software sets the two count thresholds and the two idle timeouts, enables sources, and clears raw status by writing ones. The interrupt line is the OR of every enabled raw bit.

Each coalescer is a two-state machine. In IDLE nothing is pending. In GATHER at least one event is pending, fewer than the threshold, and an age timer runs. The transitions are:
- IDLE to IDLE on a threshold hit.
- IDLE to GATHER on the first event below the threshold.
- GATHER to GATHER when an event accumulates. GATHER to GATHER also covers a timeout restart, where an event arrives in the cycle the timeout fires.
- GATHER to IDLE on a threshold hit or on a timeout with no new event.

Top module: `irq_coalesce_unit`

## Requirements
- R1: After reset these values read back: raw status 0, enable 0, masked 0, `irq_o` low, threshold word 0x0001_0001, receive timeout 0x10000 and transmit timeout 0x50000. The register word addresses are: 0 raw, 1 enable, 2 masked, 3 thresholds, 4 receive timeout, 5 transmit timeout.
- R2: A pulse on `src_evt[i]` sets raw bit i at the clock edge that samples it. The bit then holds until software clears it.
- R3: Writing address 0 clears exactly those raw bits whose write-data bit is 1. Bits written with 0 are unchanged.
- R4: A source set and a clear of the same bit in the same cycle leave the bit set.
- R5: Masked status reads raw AND enable. `irq_o` is high exactly when some masked bit is 1, so with enable 0 the line stays low.
- R6: The receive count source is raw bit 17. It is set at the edge that samples the receive event bringing the pending count up to the threshold in bits 15:0 of address 3. That edge also empties the pending count.
- R7: The transmit count source is raw bit 19. It uses the threshold in bits 31:16 of address 3 and behaves in the same way.
- R8: The receive timeout source is raw bit 28. With timeout T in address 4, it is set T+1 edges after the edge that took the first pending event, provided the threshold is not reached first. Later events do not restart this window, and an empty queue never times out.
- R9: The transmit timeout source is raw bit 29. It is timed by address 5 in the same way as R8.
- R10: Pulses on `src_evt` bits 17, 19, 28 and 29 are ignored.
- R11: An event that arrives in the cycle a timeout fires starts a new window with a pending count of one.
- R12: A threshold of 0 acts as 1, so every event raises its count source.
- R13: Enable, thresholds and timeouts read back the values written to them. Timeouts are zero-extended from 20 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| src_evt | input | 32 | One-cycle event pulses per source |
| rx_done | input | 1 | Receive descriptor written back |
| tx_done | input | 1 | Transmit descriptor returned |
| irq_o | output | 1 | Interrupt line |

## Verification
The properties assume that `rx_done`, `tx_done` and `src_evt` are single-cycle pulses that are sampled synchronously. They also assume that a clear write and a source event interact only through the set-wins rule. The write-one-to-clear property is therefore checked only in cycles with no set from any origin. The stimulus changes every input at the falling clock edge. It keeps thresholds and timeouts small, and it clears raw status between scenarios so that each coalescer starts from IDLE. Event arrivals are aligned to the exact edge on which a timeout fires, so that the restart case is exercised.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
    localparam int unsigned NSRC      = 32;
    localparam int unsigned REG_AW    = 3;
    localparam int unsigned NCH       = 2;
    localparam int unsigned THR_SHIFT = 16;

    localparam int unsigned BIT_RX_CNT = 17;
    localparam int unsigned BIT_TX_CNT = 19;
    localparam int unsigned BIT_RX_TMO = 28;
    localparam int unsigned BIT_TX_TMO = 29;

    localparam logic [REG_AW-1:0] A_RAW   = 3'd0;
    localparam logic [REG_AW-1:0] A_EN    = 3'd1;
    localparam logic [REG_AW-1:0] A_MSK   = 3'd2;
    localparam logic [REG_AW-1:0] A_THR   = 3'd3;
    localparam logic [REG_AW-1:0] A_RXTMO = 3'd4;
    localparam logic [REG_AW-1:0] A_TXTMO = 3'd5;

    localparam logic [NSRC-1:0] COAL_BITS =
        (32'd1 << BIT_RX_CNT) | (32'd1 << BIT_TX_CNT) |
        (32'd1 << BIT_RX_TMO) | (32'd1 << BIT_TX_TMO);

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_GATHER = 1'b1
    } coal_state_t;

    function automatic int unsigned cnt_bit(input int unsigned ch);
        return (ch == 0) ? BIT_RX_CNT : BIT_TX_CNT;
    endfunction

    function automatic int unsigned tmo_bit(input int unsigned ch);
        return (ch == 0) ? BIT_RX_TMO : BIT_TX_TMO;
    endfunction
endpackage

// File: rtl/irqc_coalescer.sv
`timescale 1ns/1ps
module irqc_coalescer
    import irqc_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned TMO_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [CNT_W-1:0] thresh,
    input  logic [TMO_W-1:0] tmo,
    output logic             fire_cnt,
    output logic             fire_tmo
);
    coal_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [TMO_W-1:0] tmr_q, tmr_d;
    logic [CNT_W:0]   cnt_inc;
    logic             hit_thr, hit_tmo;

    assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign hit_thr = evt && (cnt_inc >= {1'b0, thresh});
    assign hit_tmo = (state_q == ST_GATHER) && (tmr_q >= tmo) && !hit_thr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tmr_q   <= tmr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tmr_d   = tmr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hit_thr) begin
                    cnt_d = '0;
                end else if (evt) begin
                    state_d = ST_GATHER;
                    cnt_d   = {{(CNT_W-1){1'b0}}, 1'b1};
                    tmr_d   = '0;
                end
            end
            ST_GATHER: begin
                if (hit_thr) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                    tmr_d   = '0;
                end else if (hit_tmo) begin
                    tmr_d = '0;
                    if (evt) begin
                        cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
                    end else begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end
                end else begin
                    if (evt) cnt_d = cnt_inc[CNT_W-1:0];
                    tmr_d = tmr_q + {{(TMO_W-1){1'b0}}, 1'b1};
                end
            end
        endcase
    end

    always_comb begin
        fire_cnt = hit_thr;
        fire_tmo = hit_tmo;
    end
endmodule

// File: rtl/irqc_cfg_regs.sv
`timescale 1ns/1ps
module irqc_cfg_regs
    import irqc_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned TMO_W      = 20,
    parameter int unsigned RX_THR_RST = 1,
    parameter int unsigned TX_THR_RST = 1,
    parameter int unsigned RX_TMO_RST = 32'h10000,
    parameter int unsigned TX_TMO_RST = 32'h50000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      thr_we,
    input  logic [NCH-1:0]            tmo_we,
    input  logic [NSRC-1:0]           wdata,
    output logic [NCH-1:0][CNT_W-1:0] thr,
    output logic [NCH-1:0][TMO_W-1:0] tmo
);
    localparam logic [CNT_W-1:0] THR_R0 = CNT_W'(RX_THR_RST);
    localparam logic [CNT_W-1:0] THR_R1 = CNT_W'(TX_THR_RST);
    localparam logic [TMO_W-1:0] TMO_R0 = TMO_W'(RX_TMO_RST);
    localparam logic [TMO_W-1:0] TMO_R1 = TMO_W'(TX_TMO_RST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                thr[c] <= (c == 0) ? THR_R0 : THR_R1;
                tmo[c] <= (c == 0) ? TMO_R0 : TMO_R1;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (thr_we) thr[c] <= wdata[c*THR_SHIFT +: CNT_W];
                if (tmo_we[c]) tmo[c] <= wdata[TMO_W-1:0];
            end
        end
    end
endmodule

// File: rtl/irqc_status.sv
`timescale 1ns/1ps
module irqc_status
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] clr_vec,
    input  logic            en_we,
    input  logic [NSRC-1:0] en_wdata,
    output logic [NSRC-1:0] raw_q,
    output logic [NSRC-1:0] en_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
            en_q  <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_vec) | set_vec;
            if (en_we) en_q <= en_wdata;
        end
    end
endmodule

// File: rtl/irq_coalesce_unit.sv
`timescale 1ns/1ps
module irq_coalesce_unit
    import irqc_pkg::*;
#(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned TMO_W      = 20,
    parameter int unsigned RX_THR_RST = 1,
    parameter int unsigned TX_THR_RST = 1,
    parameter int unsigned RX_TMO_RST = 32'h10000,
    parameter int unsigned TX_TMO_RST = 32'h50000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] src_evt,
    input  logic        rx_done,
    input  logic        tx_done,
    output logic        irq_o
);
    logic [NCH-1:0][CNT_W-1:0] thr;
    logic [NCH-1:0][TMO_W-1:0] tmo;
    logic [NCH-1:0]            done, fire_cnt, fire_tmo, tmo_we;
    logic [NSRC-1:0]           set_vec, clr_vec, raw_q, en_q, masked;
    logic [3:0]                fire_vec;

    assign done     = {tx_done, rx_done};
    assign tmo_we   = {reg_we && (reg_addr == A_TXTMO), reg_we && (reg_addr == A_RXTMO)};
    assign fire_vec = {fire_tmo[1], fire_cnt[1], fire_tmo[0], fire_cnt[0]};

    irqc_cfg_regs #(
        .CNT_W(CNT_W), .TMO_W(TMO_W),
        .RX_THR_RST(RX_THR_RST), .TX_THR_RST(TX_THR_RST),
        .RX_TMO_RST(RX_TMO_RST), .TX_TMO_RST(TX_TMO_RST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .thr_we(reg_we && (reg_addr == A_THR)),
        .tmo_we(tmo_we), .wdata(reg_wdata),
        .thr(thr), .tmo(tmo)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        irqc_coalescer #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_coal (
            .clk(clk), .rst_n(rst_n), .evt(done[g]),
            .thresh(thr[g]), .tmo(tmo[g]),
            .fire_cnt(fire_cnt[g]), .fire_tmo(fire_tmo[g])
        );
    end

    always_comb begin
        set_vec = src_evt & ~COAL_BITS;
        for (int unsigned c = 0; c < NCH; c++) begin
            set_vec[cnt_bit(c)] = fire_cnt[c];
            set_vec[tmo_bit(c)] = fire_tmo[c];
        end
        clr_vec = (reg_we && (reg_addr == A_RAW)) ? reg_wdata : '0;
    end

    irqc_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .set_vec(set_vec), .clr_vec(clr_vec),
        .en_we(reg_we && (reg_addr == A_EN)), .en_wdata(reg_wdata),
        .raw_q(raw_q), .en_q(en_q)
    );

    assign masked = raw_q & en_q;
    assign irq_o  = |masked;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_RAW:   reg_rdata = raw_q;
            A_EN:    reg_rdata = en_q;
            A_MSK:   reg_rdata = masked;
            A_THR: begin
                reg_rdata[CNT_W-1:0]            = thr[0];
                reg_rdata[THR_SHIFT +: CNT_W]   = thr[1];
            end
            A_RXTMO: reg_rdata[TMO_W-1:0] = tmo[0];
            A_TXTMO: reg_rdata[TMO_W-1:0] = tmo[1];
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker
    import irqc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] src_evt,
    input logic        rx_done,
    input logic        tx_done,
    input logic        irq_o,
    input logic [31:0] raw_q,
    input logic [31:0] en_q,
    input logic [3:0]  fire_vec
);
    logic [31:0] src_ok;
    assign src_ok = src_evt & ~COAL_BITS;

    // R2
    src_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ok != 0) |=> ((raw_q & $past(src_ok)) == $past(src_ok)));

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_RAW && src_ok == 0 && fire_vec == 0)
        |=> ((raw_q & $past(reg_wdata)) == 0));

    // R5
    no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == 0) |-> !irq_o);

    // R6
    rx_cnt_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_vec[0] |-> rx_done);

    // R7
    tx_cnt_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_vec[2] |-> tx_done);

    // R8
    rx_single_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fire_vec[1:0]));

    // R10
    rx_bit_from_coal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_q[BIT_RX_CNT]) |-> $past(fire_vec[0]));
endmodule

bind irq_coalesce_unit irqc_checker chk_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .src_evt(src_evt), .rx_done(rx_done),
    .tx_done(tx_done), .irq_o(irq_o), .raw_q(raw_q), .en_q(en_q),
    .fire_vec(fire_vec)
);

// File: tb/irq_coalesce_unit_tb_top.sv
`timescale 1ns/10ps
module irq_coalesce_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] src_evt = '0;
    logic        rx_done = 1'b0;
    logic        tx_done = 1'b0;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    typedef struct {
        string       tag;
        bit          is_irq;
        logic [31:0] exp;
    } item_t;
    item_t sb_q[$];
    event  cmp_ev;

    always #4 clk = ~clk;

    irq_coalesce_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_evt(src_evt),
        .rx_done(rx_done), .tx_done(tx_done), .irq_o(irq_o)
    );

    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            @(cmp_ev);
            it  = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq_o} : reg_rdata;
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic chk_reg(input logic [2:0] a, input logic [31:0] e, input string tag);
        reg_addr = a;
        #0.1;
        sb_q.push_back('{tag, 1'b0, e});
        ->cmp_ev;
        #0.1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        #0.1;
        sb_q.push_back('{tag, 1'b1, {31'b0, e}});
        ->cmp_ev;
        #0.1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr_src(input logic [2:0] a, input logic [31:0] d, input logic [31:0] s);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; src_evt = s;
        @(negedge clk);
        reg_we = 1'b0; src_evt = '0;
    endtask

    task automatic pulse_src(input logic [31:0] s);
        src_evt = s;
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic pulse_rx();
        rx_done = 1'b1;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    task automatic pulse_tx();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_reg(3'd0, 32'h0, "R1 raw");
        chk_reg(3'd1, 32'h0, "R1 enable");
        chk_reg(3'd2, 32'h0, "R1 masked");
        chk_irq(1'b0, "R1 irq");
        chk_reg(3'd3, 32'h0001_0001, "R1 thresholds");
        chk_reg(3'd4, 32'h0001_0000, "R1 rx timeout");
        chk_reg(3'd5, 32'h0005_0000, "R1 tx timeout");
        // R13 readback
        wr(3'd3, 32'h0003_0002);
        wr(3'd4, 32'd10);
        wr(3'd5, 32'd6);
        chk_reg(3'd3, 32'h0003_0002, "R13 thresholds");
        chk_reg(3'd4, 32'd10, "R13 rx timeout");
        chk_reg(3'd5, 32'd6, "R13 tx timeout");
        // R2 source sets raw, R5 disabled
        pulse_src(32'h8);
        chk_reg(3'd0, 32'h8, "R2 raw set");
        chk_reg(3'd2, 32'h0, "R5 masked disabled");
        chk_irq(1'b0, "R5 irq disabled");
        wr(3'd1, 32'h8);
        chk_reg(3'd1, 32'h8, "R13 enable");
        chk_reg(3'd2, 32'h8, "R5 masked enabled");
        chk_irq(1'b1, "R5 irq enabled");
        // R3 write one to clear
        pulse_src(32'h21);
        chk_reg(3'd0, 32'h29, "R2 raw accumulates");
        wr(3'd0, 32'h8);
        chk_reg(3'd0, 32'h21, "R3 partial clear");
        chk_irq(1'b0, "R5 irq after clear");
        // R4 set wins
        wr_src(3'd0, 32'h21, 32'h1);
        chk_reg(3'd0, 32'h1, "R4 set beats clear");
        wr(3'd0, 32'hFFFF_FFFF);
        chk_reg(3'd0, 32'h0, "R3 clear all");
        // R10 coalescer bits ignored on src_evt
        pulse_src(32'h300A_0000);
        chk_reg(3'd0, 32'h0, "R10 reserved sources");
        // R6 rx count
        pulse_rx();
        chk_reg(3'd0, 32'h0, "R6 below threshold");
        pulse_rx();
        chk_reg(3'd0, 32'h0002_0000, "R6 threshold reached");
        idle(15);
        chk_reg(3'd0, 32'h0002_0000, "R8 empty queue no timeout");
        wr(3'd0, 32'hFFFF_FFFF);
        // R8 rx timeout
        pulse_rx();
        idle(10);
        chk_reg(3'd0, 32'h0, "R8 before timeout");
        idle(1);
        chk_reg(3'd0, 32'h1000_0000, "R8 timeout edge");
        wr(3'd0, 32'hFFFF_FFFF);
        // R9 tx timeout, window not restarted
        pulse_tx();
        idle(2);
        pulse_tx();
        idle(3);
        chk_reg(3'd0, 32'h0, "R9 before timeout");
        idle(1);
        chk_reg(3'd0, 32'h2000_0000, "R9 timeout from first event");
        wr(3'd0, 32'hFFFF_FFFF);
        // R7 tx count
        pulse_tx();
        pulse_tx();
        chk_reg(3'd0, 32'h0, "R7 below threshold");
        pulse_tx();
        chk_reg(3'd0, 32'h0008_0000, "R7 threshold reached");
        wr(3'd0, 32'hFFFF_FFFF);
        // R11 event on timeout edge restarts window
        wr(3'd3, 32'h0003_0003);
        pulse_rx();
        idle(10);
        pulse_rx();
        chk_reg(3'd0, 32'h1000_0000, "R11 timeout with event");
        wr(3'd0, 32'hFFFF_FFFF);
        pulse_rx();
        chk_reg(3'd0, 32'h0, "R11 count two");
        pulse_rx();
        chk_reg(3'd0, 32'h0002_0000, "R11 kept event counted");
        wr(3'd0, 32'hFFFF_FFFF);
        // R12 zero threshold
        wr(3'd3, 32'h0003_0000);
        pulse_rx();
        chk_reg(3'd0, 32'h0002_0000, "R12 zero threshold fires");
        // R5 with coalescer source
        wr(3'd1, 32'h0002_0000);
        chk_irq(1'b1, "R5 irq from count source");
        chk_reg(3'd2, 32'h0002_0000, "R5 masked count source");
        wr(3'd0, 32'h0002_0000);
        chk_irq(1'b0, "R5 irq cleared");
        idle(2);
        done_flag = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule